// File: doc/BRIEF.md
# Cascadable ALU Slice

An arithmetic-logic slice for one processing cell of a word-parallel array. Each cycle it takes an opcode, two operand bytes, a carry in and three control flags, registers all of them on entry, and on the following cycle presents a result byte, the upper half of a product and a carry out. Logic, adder, multiplier and single-bit shifter all read the registered operands.

Either operand can be bit-inverted before it reaches the function units. With the AND, OR and add functions this gives NAND, NOR, NOT and two's-complement subtraction without extra opcodes. A second control clears the incoming carry. The carry output of one slice can be wired to the carry input of the next. This lets several slices form a 16-bit or 32-bit add, subtract or shift. Each slice adds one register stage, so the upper slice's operands are presented one cycle after those of the lower slice.

Top module: `alu_slice`

## Requirements
- R1: While rst_ni is low, and on the first cycle after release, result_o, mul_hi_o and carry_o read 0.
- R2: Opcodes 0, 1 and 2 give the bitwise AND, OR and XOR of the effective operands, with carry_o = 0 and mul_hi_o = 0.
- R3: inv_a_i / inv_b_i replace the corresponding operand by its bitwise complement before any function, including shifts and multiply, which read operand A or both operands.
- R4: Opcode 3 adds the effective operands and the effective carry. result_o is the low WIDTH bits of the sum and carry_o is bit WIDTH of the sum.
- R5: Opcode 3 with inv_b_i = 1 and cin_i = 1 gives a minus b modulo 2^WIDTH. carry_o = 1 means no borrow.
- R6: The effective carry is cin_i when ign_cin_i = 0 and 0 when ign_cin_i = 1.
- R7: Opcodes 5 (left) and 7 (right) shift operand A by one and fill the vacated bit with 0. carry_o holds the bit shifted out.
- R8: Opcodes 6 (left) and 8 (right) shift operand A by one and fill the vacated bit (bit 0 for left, bit WIDTH-1 for right) with the effective carry. carry_o holds the bit shifted out.
- R9: Opcode 4 forms the full 2*WIDTH product of the effective operands. The low half goes to result_o and the high half to mul_hi_o, with carry_o = 0. mul_hi_o is 0 for every other opcode.
- R10: Outputs depend only on inputs captured at the last rising clock edge. An input change between edges leaves the outputs unchanged until the next edge.
- R11: Opcodes 9 to 15 give result_o = 0, mul_hi_o = 0 and carry_o = 0.
- R12: Two slices can be chained for a 2*WIDTH add or subtract. The lower slice's carry_o drives the upper slice's cin_i, and the upper operands are presented one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| inv_a_i | input | 1 | Complement operand A before use |
| inv_b_i | input | 1 | Complement operand B before use |
| cin_i | input | 1 | Carry in, from a neighbour slice or constant |
| ign_cin_i | input | 1 | Force the effective carry to 0 |
| result_o | output | WIDTH | Result, or low half of the product |
| mul_hi_o | output | WIDTH | High half of the product |
| carry_o | output | 1 | Carry out of add or shift |

## Verification
The properties compare each output with the inputs captured one edge earlier. They assume every input has a defined 0/1 value at each rising edge once reset is released, and that the first comparison waits one edge after release. The bench changes inputs only on falling edges, so values never move near a rising edge. Its stimulus keeps every bit at a known value, including the carry wired in from a second slice in the cascade test.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_ADD  = 4'd3,
    OP_MUL  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHLC = 4'd6,
    OP_SHR  = 4'd7,
    OP_SHRC = 4'd8
  } op_e;
endpackage

// File: rtl/alu_in_stage.sv
module alu_in_stage
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  input  logic             cin_i,
  input  logic             ign_cin_i,
  output logic [OP_W-1:0]  op_q_o,
  output logic [WIDTH-1:0] a_eff_o,
  output logic [WIDTH-1:0] b_eff_o,
  output logic             c_eff_o
);
  logic [OP_W-1:0]  op_q;
  logic [WIDTH-1:0] a_q, b_q;
  logic             inv_a_q, inv_b_q, cin_q, ign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      inv_a_q <= 1'b0;
      inv_b_q <= 1'b0;
      cin_q   <= 1'b0;
      ign_q   <= 1'b0;
    end else begin
      op_q    <= op_i;
      a_q     <= a_i;
      b_q     <= b_i;
      inv_a_q <= inv_a_i;
      inv_b_q <= inv_b_i;
      cin_q   <= cin_i;
      ign_q   <= ign_cin_i;
    end
  end

  // inversion sits after the register so the whole stage is one cycle
  always_comb begin
    op_q_o  = op_q;
    a_eff_o = inv_a_q ? ~a_q : a_q;
    b_eff_o = inv_b_q ? ~b_q : b_q;
    c_eff_o = cin_q & ~ign_q;
  end
endmodule

// File: rtl/alu_logic_shift.sv
module alu_logic_shift
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] res_o,
  output logic             co_o,
  output logic             hit_o
);
  localparam int MSB = WIDTH - 1;

  logic fill;

  always_comb begin
    res_o = '0;
    co_o  = 1'b0;
    hit_o = 1'b1;
    fill  = (op_i == OP_SHLC || op_i == OP_SHRC) ? c_i : 1'b0;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_SHL, OP_SHLC: begin
        res_o = {a_i[MSB-1:0], fill};
        co_o  = a_i[MSB];
      end
      OP_SHR, OP_SHRC: begin
        res_o = {fill, a_i[MSB:1]};
        co_o  = a_i[0];
      end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] res_o,
  output logic [WIDTH-1:0] hi_o,
  output logic             co_o,
  output logic             hit_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH:0] sum;
  logic [PW-1:0]  prod;

  always_comb begin
    sum  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};
    prod = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};
    res_o = '0;
    hi_o  = '0;
    co_o  = 1'b0;
    hit_o = 1'b1;
    unique case (op_i)
      OP_ADD: begin
        res_o = sum[WIDTH-1:0];
        co_o  = sum[WIDTH];
      end
      OP_MUL: begin
        res_o = prod[WIDTH-1:0];
        hi_o  = prod[PW-1:WIDTH];
      end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  input  logic             cin_i,
  input  logic             ign_cin_i,
  output logic [WIDTH-1:0] result_o,
  output logic [WIDTH-1:0] mul_hi_o,
  output logic             carry_o
);
  logic [OP_W-1:0]  op_q;
  logic [WIDTH-1:0] a_eff, b_eff;
  logic             c_eff;

  logic [WIDTH-1:0] ls_res, ar_res, ar_hi;
  logic             ls_co, ls_hit, ar_co, ar_hit;

  alu_in_stage #(.WIDTH(WIDTH)) u_in (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .inv_a_i   (inv_a_i),
    .inv_b_i   (inv_b_i),
    .cin_i     (cin_i),
    .ign_cin_i (ign_cin_i),
    .op_q_o    (op_q),
    .a_eff_o   (a_eff),
    .b_eff_o   (b_eff),
    .c_eff_o   (c_eff)
  );

  alu_logic_shift #(.WIDTH(WIDTH)) u_ls (
    .op_i  (op_q),
    .a_i   (a_eff),
    .b_i   (b_eff),
    .c_i   (c_eff),
    .res_o (ls_res),
    .co_o  (ls_co),
    .hit_o (ls_hit)
  );

  alu_arith #(.WIDTH(WIDTH)) u_ar (
    .op_i  (op_q),
    .a_i   (a_eff),
    .b_i   (b_eff),
    .c_i   (c_eff),
    .res_o (ar_res),
    .hi_o  (ar_hi),
    .co_o  (ar_co),
    .hit_o (ar_hit)
  );

  // unclaimed opcodes fall through to zero
  always_comb begin
    if (ls_hit) begin
      result_o = ls_res;
      mul_hi_o = '0;
      carry_o  = ls_co;
    end else if (ar_hit) begin
      result_o = ar_res;
      mul_hi_o = ar_hi;
      carry_o  = ar_co;
    end else begin
      result_o = '0;
      mul_hi_o = '0;
      carry_o  = 1'b0;
    end
  end
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             inv_a_i,
  input logic             inv_b_i,
  input logic             cin_i,
  input logic             ign_cin_i,
  input logic [WIDTH-1:0] result_o,
  input logic [WIDTH-1:0] mul_hi_o,
  input logic             carry_o
);
  // seen: one edge with reset high has passed, so $past of inputs was captured
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  function automatic logic [WIDTH:0] ref_add(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b,
                                             logic ia, logic ib, logic c, logic ig);
    logic [WIDTH:0] x, y;
    x = {1'b0, (ia ? ~a : a)};
    y = {1'b0, (ib ? ~b : b)};
    return x + y + {{WIDTH{1'b0}}, (c & ~ig)};
  endfunction

  // R4 R5 R3 R6
  assert_add_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(op_i) == OP_ADD) |->
      {carry_o, result_o} == ref_add($past(a_i), $past(b_i), $past(inv_a_i),
                                     $past(inv_b_i), $past(cin_i), $past(ign_cin_i)));

  assert_logic_no_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(op_i) <= OP_XOR) |-> (carry_o == 1'b0 && mul_hi_o == '0));

  assert_hi_only_mul_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(op_i) != OP_MUL) |-> mul_hi_o == '0);

  assert_ign_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(op_i) == OP_SHLC && $past(ign_cin_i)) |-> result_o[0] == 1'b0);

  assert_shl_zero_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(op_i) == OP_SHL) |->
      (result_o[0] == 1'b0 && carry_o == ($past(a_i[WIDTH-1]) ^ $past(inv_a_i))));

  assert_shrc_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(op_i) == OP_SHRC) |->
      result_o[WIDTH-1] == ($past(cin_i) & ~$past(ign_cin_i)));

  assert_undef_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(op_i) > OP_SHRC) |-> (result_o == '0 && mul_hi_o == '0 && !carry_o));

  assert_first_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen |-> (result_o == '0 && mul_hi_o == '0 && !carry_o));
endmodule

bind alu_slice alu_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .inv_a_i   (inv_a_i),
  .inv_b_i   (inv_b_i),
  .cin_i     (cin_i),
  .ign_cin_i (ign_cin_i),
  .result_o  (result_o),
  .mul_hi_o  (mul_hi_o),
  .carry_o   (carry_o)
);

// File: tb/sim_alu_slice.sv
module sim_alu_slice;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]   op = '0, op1 = '0;
  logic [W-1:0] a = '0, b = '0, a1 = '0, b1 = '0;
  logic ia = 0, ib = 0, ci = 0, ig = 0, ia1 = 0, ib1 = 0;
  logic [W-1:0] res, hi, res1, hi1;
  logic co, co1;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  alu_slice #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .inv_a_i(ia), .inv_b_i(ib), .cin_i(ci), .ign_cin_i(ig),
    .result_o(res), .mul_hi_o(hi), .carry_o(co)
  );

  // upper slice for the cascade test, carry wired from u0
  alu_slice #(.WIDTH(W)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op1), .a_i(a1), .b_i(b1),
    .inv_a_i(ia1), .inv_b_i(ib1), .cin_i(co), .ign_cin_i(1'b0),
    .result_o(res1), .mul_hi_o(hi1), .carry_o(co1)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model: returns {hi, carry, result} as an integer
  function automatic int model(int o, int av, int bv, bit xa, bit xb, bit c, bit g);
    int ea, eb, cc, r, h, k, s, p;
    ea = xa ? 255 - av : av;
    eb = xb ? 255 - bv : bv;
    cc = (c && !g) ? 1 : 0;
    r = 0; h = 0; k = 0;
    case (o)
      0: r = ea & eb;
      1: r = ea | eb;
      2: r = ea ^ eb;
      3: begin s = ea + eb + cc; r = s % 256; k = s / 256; end
      4: begin p = ea * eb; r = p % 256; h = p / 256; end
      5: begin r = (ea * 2) % 256; k = ea / 128; end
      6: begin r = (ea * 2 + cc) % 256; k = ea / 128; end
      7: begin r = ea / 2; k = ea % 2; end
      8: begin r = ea / 2 + cc * 128; k = ea % 2; end
      default: ;
    endcase
    return h * 512 + k * 256 + r;
  endfunction

  function automatic string tag_of(int o, bit xa, bit xb, bit g);
    if (g) return "R6";
    if (o > 8) return "R11";
    if (o == 4) return "R9";
    if (o == 6 || o == 8) return "R8";
    if (o == 5 || o == 7) return "R7";
    if (o == 3) return xb ? "R5" : "R4";
    if (xa || xb) return "R3";
    return "R2";
  endfunction

  task automatic apply(int o, int av, int bv, bit xa, bit xb, bit c, bit g);
    int e;
    @(negedge clk);
    op = 4'(o); a = W'(av); b = W'(bv); ia = xa; ib = xb; ci = c; ig = g;
    @(posedge clk);
    #1;
    e = model(o, av, bv, xa, xb, c, g);
    check(tag_of(o, xa, xb, g), {hi, co, res}, e);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int e;
    repeat (3) @(posedge clk);
    #1 check("R1", {hi, co, res}, 0);
    @(negedge clk);
    op = 4'd3; a = 8'hff; b = 8'hff; ci = 1;
    rst_n = 1'b1;
    #1 check("R1", {hi, co, res}, 0);

    // R2 R3 logic, NAND/NOR/NOT
    apply(0, 8'hf0, 8'h3c, 0, 0, 0, 0);
    apply(1, 8'h81, 8'h18, 0, 0, 1, 0);
    apply(2, 8'haa, 8'h0f, 0, 0, 0, 0);
    apply(0, 8'hf0, 8'h3c, 1, 1, 0, 0);   // NOR via inverted AND
    apply(1, 8'hf0, 8'h3c, 1, 1, 0, 0);   // NAND
    apply(1, 8'h5a, 8'h00, 1, 0, 0, 0);   // NOT
    // R4 add
    apply(3, 8'hff, 8'h01, 0, 0, 0, 0);
    apply(3, 8'h7f, 8'h80, 0, 0, 1, 0);
    apply(3, 8'h12, 8'h34, 0, 0, 0, 0);
    // R5 subtract
    apply(3, 8'h05, 8'h03, 0, 1, 1, 0);
    apply(3, 8'h03, 8'h05, 0, 1, 1, 0);
    apply(3, 8'h40, 8'h40, 0, 1, 1, 0);
    // R6 ignore carry
    apply(3, 8'hff, 8'h00, 0, 0, 1, 1);
    apply(6, 8'h01, 8'h00, 0, 0, 1, 1);
    // R7 / R8 shifts
    apply(5, 8'h81, 8'h00, 0, 0, 1, 0);
    apply(7, 8'h81, 8'h00, 0, 0, 1, 0);
    apply(6, 8'h81, 8'h00, 0, 0, 1, 0);
    apply(8, 8'h02, 8'h00, 0, 0, 1, 0);
    apply(8, 8'h03, 8'h00, 1, 0, 0, 0);
    // R9 multiply
    apply(4, 8'hff, 8'hff, 0, 0, 0, 0);
    apply(4, 8'h10, 8'h20, 0, 0, 0, 0);
    apply(4, 8'h00, 8'h0f, 1, 0, 0, 0);
    // R11 undefined codes
    for (int o = 9; o < 16; o++) apply(o, 8'hff, 8'hff, 1, 1, 1, 0);

    // R10: inputs move between edges, outputs hold
    apply(3, 8'h11, 8'h22, 0, 0, 0, 0);
    #1 op = 4'd4; a = 8'hff; b = 8'hff;
    #2 check("R10", {hi, co, res}, 32'h033);

    // mixed patterns across all codes
    for (int i = 0; i < 300; i++)
      apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom_range(0, 3) == 0));

    // R12 cascade: 16-bit 0x12FF + 0x0001 = 0x1300
    apply(3, 8'hff, 8'h01, 0, 0, 0, 0);
    @(negedge clk);
    op1 = 4'd3; a1 = 8'h12; b1 = 8'h00; ia1 = 0; ib1 = 0;
    op = 4'd0;
    @(posedge clk); #1;
    e = model(3, 8'h12, 8'h00, 0, 0, 1, 0);
    check("R12", {co1, res1}, e);
    // R12 cascade: 16-bit 0x0100 - 0x0001 = 0x00FF, no borrow
    apply(3, 8'h00, 8'h01, 0, 1, 1, 0);
    @(negedge clk);
    op1 = 4'd3; a1 = 8'h01; b1 = 8'h00; ia1 = 0; ib1 = 1;
    op = 4'd0;
    @(posedge clk); #1;
    check("R12", {co1, res1}, 32'h100);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule